// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition and Control Flags

This block performs one arithmetic or logical operation per enabled clock cycle on byte or word operands. The result goes into a result register. A 16-bit status word is updated alongside it. Addition, addition with carry-in, subtraction, subtraction with borrow-in, AND, OR, XOR and bitwise inversion are supported. The carry-in and borrow-in come from the stored carry flag, so multi-precision arithmetic can be chained over several cycles.

The status word holds six condition flags and three control flags. Operation results drive the condition flags: carry, parity, nibble (auxiliary) carry, zero, sign and overflow. The control flags are trap, interrupt-enable and direction. They change only through dedicated write strobes and are never touched by a result. A byte/word select picks which lane sets the sign, carry and overflow. Parity always looks at the low byte only. The reset input asserts asynchronously and is expected to be released synchronously to the clock.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is asserted, `result` reads 0 and `flags` reads 16'h0002.
- R2: With `en` high, opcode 0 (add) and opcode 1 (add with carry-in equal to stored flag bit 0) register the sum truncated to the selected width. Flag bit 0 (CF) is set to the unsigned carry out of bit 7 (byte) or bit 15 (word).
- R3: Opcode 2 (subtract) and opcode 3 (subtract with borrow-in equal to stored flag bit 0) register a − b − borrow truncated to width. CF is set exactly when b plus borrow-in exceeds a as unsigned values.
- R4: For opcodes 0 to 3, flag bit 11 (OF) is set exactly when the signed result at the selected width falls outside the signed range.
- R5: For opcodes 0 to 3, flag bit 4 (AF) is set exactly when a carry leaves bit 3 (addition) or a borrow enters bit 3 (subtraction).
- R6: For opcodes 0 to 6, flag bit 2 (PF) is 1 when bits 7:0 of the result hold an even number of ones and 0 otherwise, in both widths.
- R7: For opcodes 0 to 6, flag bit 6 (ZF) is 1 exactly when the width-truncated result is zero. Flag bit 7 (SF) equals result bit 7 (byte) or bit 15 (word).
- R8: Opcodes 4, 5 and 6 register a AND b, a OR b and a XOR b. They clear CF and OF, keep AF, and update PF, ZF and SF.
- R9: Opcode 7 registers the bitwise inverse of a at the selected width and leaves every condition flag unchanged.
- R10: Flag bits 8 (trap), 9 (interrupt-enable) and 10 (direction) take `ctl_val[k]` when `ctl_we[k]` is high, for k = 0, 1, 2. They hold otherwise, whatever operation runs. The strobes act with or without `en` and never alter condition flags.
- R11: With `en` low, `result` and all condition flags hold their values.
- R12: With `word` = 0 (byte mode) only bits 7:0 of `a` and `b` are used, and result bits 15:8 read 0.
- R13: Flag bit 1 always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Perform the operation on this edge |
| op | input | 3 | Opcode: 0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 and, 5 or, 6 xor, 7 not |
| word | input | 1 | 1 selects 16-bit operands, 0 selects 8-bit |
| a | input | 16 | First operand (minuend) |
| b | input | 16 | Second operand (subtrahend) |
| ctl_we | input | 3 | Write strobes for trap, interrupt-enable, direction |
| ctl_val | input | 3 | Values written by the strobes |
| result | output | 16 | Registered result |
| flags | output | 16 | Status word |

## Verification
Byte mode is swept over a grid of operand values for every opcode. The grid includes 0x00, 0x01, 0x7F, 0x80 and 0xFF, and each opcode is run with the stored carry both clear and set, which separates carry from overflow and nibble carry from full carry. Random upper bytes in byte mode show that the unused lane is ignored. Word mode uses a square of edge values plus random pairs, so sign, overflow and zero are checked at bit 15 rather than bit 7. Random control-flag strobes run during operations and during idle cycles, which shows the two flag groups never disturb each other.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOT = 3'd7
  } alu_op_e;

  // Bit positions inside the status word
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_OF = 11;

  localparam int        CTL_N      = 3;
  localparam int        FLAG_W     = 16;
  localparam logic [15:0] FLAG_FIXED = 16'h0002;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } cond_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         word,
  output logic [W-1:0] sum,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int H = W / 2;

  logic [W-1:0] bv;
  logic         c0;
  logic [W:0]   s_word;
  logic [H:0]   s_byte;
  logic [4:0]   s_nib;
  logic         co;
  logic         sa;
  logic         sb;
  logic         sr;

  always_comb begin
    // Subtraction: a + ~b + ~borrow
    bv     = sub ? ~b : b;
    c0     = sub ^ cin;
    s_word = {1'b0, a} + {1'b0, bv} + {{W{1'b0}}, c0};
    s_byte = {1'b0, a[H-1:0]} + {1'b0, bv[H-1:0]} + {{H{1'b0}}, c0};
    s_nib  = {1'b0, a[3:0]} + {1'b0, bv[3:0]} + {4'b0, c0};

    if (word) begin
      sum = s_word[W-1:0];
      co  = s_word[W];
      sa  = a[W-1];
      sb  = bv[W-1];
      sr  = s_word[W-1];
    end else begin
      sum = {{(W-H){1'b0}}, s_byte[H-1:0]};
      co  = s_byte[H];
      sa  = a[H-1];
      sb  = bv[H-1];
      sr  = s_byte[H-1];
    end

    cf = co ^ sub;
    af = s_nib[4] ^ sub;
    of = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
  import alu_flags_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  cond_t               cond_in,
  input  logic [CTL_N-1:0]    ctl_we,
  input  logic [CTL_N-1:0]    ctl_val,
  output logic [FLAG_W-1:0]   flags
);
  cond_t            cond_q, cond_d;
  logic [CTL_N-1:0] ctl_q, ctl_d;

  always_comb begin
    cond_d = cond_q;
    if (upd) cond_d = cond_in;
  end

  for (genvar k = 0; k < CTL_N; k++) begin : g_ctl
    assign ctl_d[k] = ctl_we[k] ? ctl_val[k] : ctl_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ctl_q  <= '0;
    end else begin
      cond_q <= cond_d;
      ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    flags                      = FLAG_FIXED;
    flags[FB_CF]               = cond_q.cf;
    flags[FB_PF]               = cond_q.pf;
    flags[FB_AF]               = cond_q.af;
    flags[FB_ZF]               = cond_q.zf;
    flags[FB_SF]               = cond_q.sf;
    flags[FB_OF]               = cond_q.of;
    flags[FB_TF+CTL_N-1:FB_TF] = ctl_q;
  end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    op,
  input  logic          word,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [2:0]    ctl_we,
  input  logic [2:0]    ctl_val,
  output logic [W-1:0]  result,
  output logic [15:0]   flags
);
  localparam int H = W / 2;

  alu_op_e      op_e;
  logic         is_arith;
  logic         carry_in;
  logic [W-1:0] as_sum;
  logic         as_cf, as_af, as_of;
  logic [W-1:0] lg_y;
  logic [W-1:0] res_d;
  logic [W-1:0] res_q, res_n;
  cond_t        cond_in;
  logic         upd;

  assign op_e     = alu_op_e'(op);
  assign is_arith = (op_e == OP_ADD) || (op_e == OP_ADC) ||
                    (op_e == OP_SUB) || (op_e == OP_SBB);
  assign carry_in = ((op_e == OP_ADC) || (op_e == OP_SBB)) && flags[FB_CF];

  alu_addsub #(.W(W)) u_addsub (
    .a    (a),
    .b    (b),
    .cin  (carry_in),
    .sub  ((op_e == OP_SUB) || (op_e == OP_SBB)),
    .word (word),
    .sum  (as_sum),
    .cf   (as_cf),
    .af   (as_af),
    .of   (as_of)
  );

  alu_logic #(.W(W)) u_logic (
    .a   (a),
    .b   (b),
    .sel (op[1:0]),
    .y   (lg_y)
  );

  always_comb begin
    if (is_arith)  res_d = as_sum;
    else if (word) res_d = lg_y;
    else           res_d = {{(W-H){1'b0}}, lg_y[H-1:0]};

    cond_in.zf = (res_d == '0);
    cond_in.sf = word ? res_d[W-1] : res_d[H-1];
    cond_in.pf = ~^res_d[H-1:0];
    if (is_arith) begin
      cond_in.cf = as_cf;
      cond_in.af = as_af;
      cond_in.of = as_of;
    end else begin
      cond_in.cf = 1'b0;
      cond_in.af = flags[FB_AF];
      cond_in.of = 1'b0;
    end

    upd   = en && (op_e != OP_NOT);
    res_n = en ? res_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_n;
  end

  assign result = res_q;

  alu_flagreg u_flagreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .cond_in (cond_in),
    .ctl_we  (ctl_we),
    .ctl_val (ctl_val),
    .flags   (flags)
  );

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [2:0]   op,
  input logic         word,
  input logic [W-1:0] result,
  input logic [15:0]  flags,
  input logic [2:0]   ctl_we,
  input logic [2:0]   ctl_val
);
  localparam int H = W / 2;
  localparam logic [15:0] COND_MASK = 16'h08D5;

  a_r13_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0002);

  a_r9_not_keeps_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd7) |=> ((flags & COND_MASK) == $past(flags & COND_MASK)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (result == $past(result)) &&
            ((flags & COND_MASK) == $past(flags & COND_MASK)));

  a_r8_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=>
      (!flags[0] && !flags[11] && flags[4] == $past(flags[4])));

  a_r7_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op != 3'd7) |=>
      (flags[6] == ($past(word) ? (result == '0) : (result[H-1:0] == '0))));

  a_r12_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !word) |=> (result[W-1:H] == '0));

  for (genvar k = 0; k < 3; k++) begin : g_ctl
    a_r10_ctl_set: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we[k] |=> (flags[8+k] == $past(ctl_val[k])));
    a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we[k] |=> (flags[8+k] == $past(flags[8+k])));
  end

endmodule

bind alu_flags_unit alu_flags_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .op      (op),
  .word    (word),
  .result  (result),
  .flags   (flags),
  .ctl_we  (ctl_we),
  .ctl_val (ctl_val)
);

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [2:0]  op;
  logic        word;
  logic [15:0] a, b;
  logic [2:0]  ctl_we, ctl_val;
  logic [15:0] result;
  logic [15:0] flags;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_res;
  logic [15:0] exp_fl;

  always #5 clk = ~clk;

  alu_flags_unit dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .word(word),
    .a(a), .b(b), .ctl_we(ctl_we), .ctl_val(ctl_val),
    .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // Returns {result, flags} expected after one enabled operation
  function automatic logic [31:0] model(input logic [2:0] o, input logic w,
                                        input logic [15:0] x, input logic [15:0] y,
                                        input logic [15:0] fl);
    int mask, half, ua, ub, c, r, sa, sb, ss, msb;
    logic [15:0] nf;
    logic cf, af, ovf;
    mask = w ? 'hFFFF : 'hFF;
    half = (mask + 1) / 2;
    msb  = w ? 15 : 7;
    ua = int'(x) & mask;
    ub = int'(y) & mask;
    c  = ((o == 3'd1) || (o == 3'd3)) ? int'(fl[0]) : 0;
    sa = (ua >= half) ? ua - (mask + 1) : ua;
    sb = (ub >= half) ? ub - (mask + 1) : ub;
    nf = fl;
    cf = 1'b0; af = fl[4]; ovf = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        r   = (ua + ub + c) & mask;
        cf  = (ua + ub + c) > mask;
        af  = ((ua & 15) + (ub & 15) + c) > 15;
        ss  = sa + sb + c;
        ovf = (ss > half - 1) || (ss < -half);
      end
      3'd2, 3'd3: begin
        r   = (ua - ub - c) & mask;
        cf  = (ub + c) > ua;
        af  = ((ub & 15) + c) > (ua & 15);
        ss  = sa - sb - c;
        ovf = (ss > half - 1) || (ss < -half);
      end
      3'd4: r = ua & ub;
      3'd5: r = ua | ub;
      3'd6: r = ua ^ ub;
      default: r = (~ua) & mask;
    endcase
    if (o != 3'd7) begin
      nf[0]  = cf;
      nf[2]  = ($countones(r[7:0]) % 2) == 0;
      nf[4]  = af;
      nf[6]  = (r == 0);
      nf[7]  = r[msb];
      nf[11] = ovf;
    end
    return {r[15:0], nf};
  endfunction

  task automatic do_op(input logic [2:0] o, input logic w, input logic [15:0] x,
                       input logic [15:0] y, input logic [2:0] we, input logic [2:0] val);
    logic [31:0] m;
    logic [15:0] er, ef;
    string cls, ctag, otag, atag, ztag;
    op = o; word = w; a = x; b = y; en = 1'b1; ctl_we = we; ctl_val = val;
    m  = model(o, w, x, y, exp_fl);
    er = m[31:16];
    ef = m[15:0];
    for (int k = 0; k < 3; k++) if (we[k]) ef[8+k] = val[k];
    @(negedge clk);
    cls  = (o < 2) ? "R2" : (o < 4) ? "R3" : (o < 7) ? "R8" : "R9";
    otag = (o < 4) ? "R4" : cls;
    atag = (o < 4) ? "R5" : cls;
    ctag = (o < 7) ? "R6" : cls;
    ztag = (o < 7) ? "R7" : cls;
    chk({cls, " result"}, int'(result), int'(er));
    if (!w) chk("R12 upper byte", int'(result[15:8]), 0);
    chk({cls, " CF"}, int'(flags[0]), int'(ef[0]));
    chk({otag, " OF"}, int'(flags[11]), int'(ef[11]));
    chk({atag, " AF"}, int'(flags[4]), int'(ef[4]));
    chk({ctag, " PF"}, int'(flags[2]), int'(ef[2]));
    chk({ztag, " ZF"}, int'(flags[6]), int'(ef[6]));
    chk({ztag, " SF"}, int'(flags[7]), int'(ef[7]));
    chk("R10 control", int'(flags[10:8]), int'(ef[10:8]));
    chk("R13 fixed", int'(flags & 16'hF02A), 2);
    exp_res = er;
    exp_fl  = ef;
    en = 1'b0; ctl_we = 3'b0;
  endtask

  function automatic logic [7:0] bval(input int i);
    if (i < 18)       return 8'(i * 15);
    else if (i == 18) return 8'h7F;
    else if (i == 19) return 8'h80;
    else              return 8'h01;
  endfunction

  function automatic logic [15:0] wval(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;
      2: return 16'h7FFF;  3: return 16'h8000;
      4: return 16'hFFFF;  5: return 16'h00FF;
      6: return 16'h0100;  default: return 16'h0F0F;
    endcase
  endfunction

  task automatic set_carry(input logic c);
    if (c) do_op(3'd0, 1'b0, 16'h00FF, 16'h0001, 3'b0, 3'b0);
    else   do_op(3'd0, 1'b0, 16'h0000, 16'h0000, 3'b0, 3'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = 3'd0; word = 1'b0;
    a = '0; b = '0; ctl_we = '0; ctl_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset flags", int'(flags), 2);
    rst_n = 1'b1;
    exp_res = 16'h0;
    exp_fl  = 16'h0002;
    @(negedge clk);

    // byte-mode grid, random upper bytes, both stored carries
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 21; i++)
        for (int j = 0; j < 21; j++)
          for (int c = 0; c < 2; c++) begin
            set_carry(c[0]);
            do_op(3'(o), 1'b0, {8'($urandom), bval(i)}, {8'($urandom), bval(j)},
                  3'($urandom), 3'($urandom));
          end

    // word-mode edge square
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++) begin
            set_carry(c[0]);
            do_op(3'(o), 1'b1, wval(i), wval(j), 3'($urandom), 3'($urandom));
          end

    // word-mode random pairs
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 300; n++) begin
        set_carry(n[0]);
        do_op(3'(o), 1'b1, 16'($urandom), 16'($urandom), 3'($urandom), 3'($urandom));
      end

    // idle cycles: R11, and strobes alone leave condition flags alone (R10)
    for (int n = 0; n < 64; n++) begin
      set_carry(n[1]);
      en = 1'b0; op = 3'($urandom); word = 1'($urandom);
      a = 16'($urandom); b = 16'($urandom);
      ctl_we = n[0] ? 3'($urandom) : 3'b0;
      ctl_val = 3'($urandom);
      for (int k = 0; k < 3; k++) if (ctl_we[k]) exp_fl[8+k] = ctl_val[k];
      @(negedge clk);
      chk("R11 idle result", int'(result), int'(exp_res));
      chk("R11 idle cond flags", int'(flags & 16'h08D5), int'(exp_fl & 16'h08D5));
      chk("R10 idle control", int'(flags[10:8]), int'(exp_fl[10:8]));
      ctl_we = 3'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule